// File: doc/BRIEF.md
# SPI Master with Register-Controlled FIFOs

This block is a serial peripheral interface master that sits behind a small 32-bit memory-mapped register port. Software writes words into a transmit queue and picks a clock polarity, clock phase and bit order. It then releases a transmit hold bit, and the block shifts each queued word out on `mosi` while it captures `miso` into a receive queue. Each word sent produces exactly one word received, so software can drain the receive queue once the transmit queue is empty.

The word width, the queue depth, the number of slave-select lines and the serial clock divider are fixed by elaboration parameters. Software cannot program any of them. Slave select is active low. It can follow its register at all times (manual mode), or it can be driven only while a burst of back-to-back words is in progress (automatic mode). A loopback bit feeds the outgoing serial data into the receiver in place of `miso`. Reads are registered: `rdata` is valid in the cycle after `rd_en`.

Top module: `spi_fifo_master`

## Requirements
- R1: The control register at offset 0x60 reads back what was written in bits 0 (loopback), 1 (enable), 2 (master), 3 (clock polarity), 4 (clock phase), 7 (manual select), 8 (transmit hold) and 9 (LSB first), and resets to 0x100. The select register at 0x70 resets to all ones. Read data appears in the cycle after `rd_en`.
- R2: The status register at 0x64 reports receive-empty in bit 0, receive-full in bit 1, transmit-empty in bit 2 and transmit-full in bit 3. Bit 4 (mode fault) always reads 0.
- R3: While the transmit hold bit is set, no word starts, even when the transmit queue holds data. `sck` stays at its idle level and the select lines stay high in automatic mode.
- R4: A word starts only when the enable bit and the master bit are both set.
- R5: A write to 0x68 queues a word and a read of 0x6C pops one. Each word sent pushes one received word. With bit 9 clear the most significant bit goes first on the wire; with bit 9 set the least significant bit goes first.
- R6: `sck` idles at the polarity bit. With phase 0 both sides sample on leading edges, and with phase 1 on trailing edges. Each word takes 2*WORD_W clock edges.
- R7: With loopback set, the receiver takes `mosi` and ignores `miso`.
- R8: In manual mode `ss_n` follows the select register. In automatic mode `ss_n` is all ones while idle and equals the select register for a burst, staying low across back-to-back words.
- R9: Writing 1 to control bit 5 or bit 6 empties the transmit queue or the receive queue, respectively. These bits read back as 0.
- R10: A write to a full transmit queue is dropped, and a read of an empty receive queue does not change the queue.
- R11: Within a word, successive `sck` edges are CLK_DIV system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
A wrong shift-engine state shows on `sck` and `mosi` within one half period. It appears as extra or missing edges, a wrong idle level, or a wrong bit captured by the bench slave model. A queue pointer error shows in the status word on the next read, and in the received data once the queue is drained. Slave-select errors show as a glitch between back-to-back words or as an extra rise, counted across the whole burst. The sweep covers all four clock modes under both bit orders, as well as full, empty and reset queue states.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h60;
  localparam logic [7:0] OFS_STAT = 8'h64;
  localparam logic [7:0] OFS_TXD  = 8'h68;
  localparam logic [7:0] OFS_RXD  = 8'h6C;
  localparam logic [7:0] OFS_SEL  = 8'h70;

  localparam int CB_LOOP = 0;
  localparam int CB_EN   = 1;
  localparam int CB_MSTR = 2;
  localparam int CB_CPOL = 3;
  localparam int CB_CPHA = 4;
  localparam int CB_TCLR = 5;
  localparam int CB_RCLR = 6;
  localparam int CB_MAN  = 7;
  localparam int CB_HOLD = 8;
  localparam int CB_LSB  = 9;
  localparam int CTRL_W  = 10;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 10'h100;
  localparam logic [CTRL_W-1:0] CTRL_PULSE = 10'h060;

  typedef enum logic [1:0] {ENG_IDLE, ENG_FETCH, ENG_SHIFT, ENG_DONE} eng_state_t;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> full);
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> empty);
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/spim_engine.sv
`timescale 1ns/1ps
module spim_engine
  import spim_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb,
  input  logic              cfg_loop,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int EW = $clog2(2 * WORD_W);
  localparam logic [CW-1:0] DIV_TOP  = CW'(CLK_DIV - 1);
  localparam logic [EW-1:0] EDGE_END = EW'(2 * WORD_W - 1);

  eng_state_t        st;
  logic [CW-1:0]     div;
  logic [EW-1:0]     edge_n;
  logic [WORD_W-1:0] sh, rsh;
  logic              sck_q, start, smp, rx_in;

  assign start  = go && !tx_empty && (st == ENG_IDLE || st == ENG_DONE);
  assign tx_pop = start;
  assign busy   = (st != ENG_IDLE);
  assign sck    = sck_q;
  assign mosi   = cfg_lsb ? sh[0] : sh[WORD_W-1];
  assign rx_in  = cfg_loop ? mosi : miso;
  assign smp    = (edge_n[0] == cfg_cpha);
  assign rx_data = rsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ENG_IDLE;
      sck_q   <= 1'b0;
      sh      <= '0;
      rsh     <= '0;
      div     <= '0;
      edge_n  <= '0;
      rx_push <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      case (st)
        ENG_IDLE: begin
          sck_q <= cfg_cpol;
          if (start) st <= ENG_FETCH;
        end
        ENG_FETCH: begin
          sh     <= tx_data;
          div    <= DIV_TOP;
          edge_n <= '0;
          st     <= ENG_SHIFT;
        end
        ENG_SHIFT: begin
          if (div == '0) begin
            div    <= DIV_TOP;
            sck_q  <= ~sck_q;
            edge_n <= edge_n + 1'b1;
            if (smp) begin
              rsh <= cfg_lsb ? {rx_in, rsh[WORD_W-1:1]} : {rsh[WORD_W-2:0], rx_in};
            end else if (!(cfg_cpha && edge_n == '0)) begin
              sh <= cfg_lsb ? (sh >> 1) : (sh << 1);
            end
            if (edge_n == EDGE_END) st <= ENG_DONE;
          end else begin
            div <= div - 1'b1;
          end
        end
        default: begin
          rx_push <= 1'b1;
          st      <= start ? ENG_FETCH : ENG_IDLE;
        end
      endcase
    end
  end

  assert_hold_between_ticks_R11: assert property (@(posedge clk) disable iff (rst)
    (st == ENG_SHIFT && div != '0) |=> $stable(sck_q));
endmodule

// File: rtl/spi_fifo_master.sv
`timescale 1ns/1ps
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int DEPTH   = 16,
  parameter int NUM_SS  = 4,
  parameter int CLK_DIV = 2,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n
);
  logic [CTRL_W-1:0] ctl_q;
  logic [NUM_SS-1:0] sel_q, ss_n_q;
  logic [31:0]       rdata_q;
  logic              rd_rx_q;
  logic              hit_ctrl, hit_txd, hit_rxd, hit_sel, hit_stat;
  logic              tx_clr, rx_clr, go;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_pop, rx_push, eng_busy;
  logic [WORD_W-1:0] tx_dout, rx_din, rx_dout;
  logic [31:0]       status_w;
  logic              unused_wdata;

  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (addr == ADDR_W'(OFS_STAT));
  assign hit_txd  = (addr == ADDR_W'(OFS_TXD));
  assign hit_rxd  = (addr == ADDR_W'(OFS_RXD));
  assign hit_sel  = (addr == ADDR_W'(OFS_SEL));

  assign tx_clr = wr_en && hit_ctrl && wdata[CB_TCLR];
  assign rx_clr = wr_en && hit_ctrl && wdata[CB_RCLR];
  assign go     = ctl_q[CB_EN] && ctl_q[CB_MSTR] && !ctl_q[CB_HOLD];
  assign status_w = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
  assign unused_wdata = ^wdata;

  spim_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) i_txq (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(wr_en && hit_txd), .din(wdata[WORD_W-1:0]),
    .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full));

  spim_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(rx_push), .din(rx_din),
    .pop(rd_en && hit_rxd), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

  spim_engine #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) i_eng (
    .clk(clk), .rst(rst), .go(go),
    .cfg_cpol(ctl_q[CB_CPOL]), .cfg_cpha(ctl_q[CB_CPHA]),
    .cfg_lsb(ctl_q[CB_LSB]), .cfg_loop(ctl_q[CB_LOOP]),
    .tx_empty(tx_empty), .tx_data(tx_dout), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_din), .busy(eng_busy),
    .sck(sck), .mosi(mosi), .miso(miso));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= CTRL_RESET;
      sel_q   <= '1;
      ss_n_q  <= '1;
      rdata_q <= '0;
      rd_rx_q <= 1'b0;
    end else begin
      if (wr_en && hit_ctrl) ctl_q <= wdata[CTRL_W-1:0] & ~CTRL_PULSE;
      if (wr_en && hit_sel)  sel_q <= wdata[NUM_SS-1:0];
      ss_n_q  <= (ctl_q[CB_MAN] || eng_busy) ? sel_q : '1;
      rd_rx_q <= rd_en && hit_rxd;
      if (rd_en) begin
        if (hit_ctrl)      rdata_q <= 32'(ctl_q);
        else if (hit_stat) rdata_q <= status_w;
        else if (hit_sel)  rdata_q <= 32'(sel_q);
        else               rdata_q <= '0;
      end
    end
  end

  assign rdata = rd_rx_q ? 32'(rx_dout) : rdata_q;
  assign ss_n  = ss_n_q;

  assert_hold_blocks_start_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[CB_HOLD] && !eng_busy) |=> !eng_busy);
  assert_needs_enable_master_R4: assert property (@(posedge clk) disable iff (rst)
    (!(ctl_q[CB_EN] && ctl_q[CB_MSTR]) && !eng_busy) |=> !eng_busy);
  assert_auto_select_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[CB_MAN] && !eng_busy) |=> (ss_n == '1));
endmodule

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module test_spi_fifo_master;
  localparam int W = 8;
  localparam int DEPTH = 4;
  localparam int NSS = 4;
  localparam int DIV = 2;
  localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
                         A_RXD = 8'h6C, A_SEL = 8'h70;
  localparam int C_LOOP = 1, C_EN = 2, C_MS = 4, C_CPOL = 8, C_CPHA = 16,
                 C_TCLR = 32, C_RCLR = 64, C_MAN = 128, C_HOLD = 256, C_LSB = 512;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, miso = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic sck, mosi;
  logic [NSS-1:0] ss_n;

  int errors = 0, checks = 0;
  bit done = 0;

  bit cfg_cpol = 0, cfg_cpha = 0, cfg_lsb = 0;
  logic [W-1:0] sw [8];
  logic [W-1:0] rcv [8];
  int tog_cnt = 0, gap_ok = 0, gap_bad = 0, ss_rise = 0, widx = 0, bitk = 0;
  time last_t = 0;
  bit have_last = 0;
  logic ss_prev = 1, sck_prev = 0;

  spi_fifo_master #(.WORD_W(W), .DEPTH(DEPTH), .NUM_SS(NSS), .CLK_DIV(DIV), .ADDR_W(8)) i_spi_fifo_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  always #10 clk = ~clk;

  function automatic logic pick(input int wi, input int k);
    logic [W-1:0] v;
    v = (wi < 8) ? sw[wi] : '0;
    return cfg_lsb ? v[k] : v[W-1-k];
  endfunction

  // bench slave on select line 0
  always @(sck or ss_n[0]) begin
    if (ss_n[0] !== ss_prev) begin
      ss_prev = ss_n[0];
      if (!ss_n[0]) begin
        bitk = 0; widx = 0; have_last = 0;
        for (int i = 0; i < 8; i++) rcv[i] = '0;
        miso = pick(0, 0);
      end else ss_rise++;
    end
    if (sck !== sck_prev) begin
      sck_prev = sck;
      tog_cnt++;
      if (!ss_n[0]) begin
        if (have_last) begin
          if ($time - last_t == 40) gap_ok++;
          else if ($time - last_t < 40) gap_bad++;
        end
        last_t = $time; have_last = 1;
        if ((sck != cfg_cpol) == !cfg_cpha) begin
          if (widx < 8) rcv[widx][cfg_lsb ? bitk : W-1-bitk] = mosi;
          bitk++;
          if (bitk == W) begin bitk = 0; widx++; end
          miso = pick(widx, bitk);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input int d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon;
    tog_cnt = 0; gap_ok = 0; gap_bad = 0; ss_rise = 0;
  endtask

  initial begin
    int v;
    for (int i = 0; i < 8; i++) sw[i] = 8'hFF;
    idle(3); rst = 0; idle(2);
    // R1 / R2 reset state
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h100);
    rd(A_STAT, v); chk("R2 status reset", v, 32'h05);
    rd(A_SEL, v);  chk("R1 select reset", v, 32'hF);
    chk("R8 ss_n reset", ss_n, 4'hF);
    chk("R6 sck reset", sck, 0);
    // R1 / R9 readback, pulse bits read 0
    wr(A_CTRL, 32'h3FF); rd(A_CTRL, v); chk("R1 R9 ctrl readback", v, 32'h39F);
    wr(A_CTRL, C_HOLD); idle(2);

    // R3 / R4 gating
    cfg_cpol = 0; cfg_cpha = 0; cfg_lsb = 0; sw[0] = 8'h3C;
    wr(A_SEL, 32'hE);
    wr(A_CTRL, C_EN | C_MS | C_HOLD);
    wr(A_TXD, 32'hA5); idle(3); clear_mon;
    idle(60);
    chk("R3 no sck while held", tog_cnt, 0);
    chk("R3 select idle while held", ss_n, 4'hF);
    rd(A_STAT, v); chk("R2 tx pending status", v, 32'h01);
    wr(A_CTRL, C_MS); idle(60); chk("R4 no start without enable", tog_cnt, 0);
    wr(A_CTRL, C_EN); idle(60); chk("R4 no start without master", tog_cnt, 0);
    wr(A_CTRL, C_EN | C_MS); idle(60);
    chk("R4 starts when enabled", tog_cnt, 2 * W);
    rd(A_STAT, v); chk("R2 one word done status", v, 32'h04);
    rd(A_RXD, v); chk("R5 rx gated word", v, 32'h3C);
    chk("R5 slave got gated word", rcv[0], 8'hA5);

    // R5 / R6 / R8 / R11 sweep of modes and bit orders
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 2; l++) begin
        logic [W-1:0] tx [2];
        int ctl;
        cfg_cpol = m[0]; cfg_cpha = m[1]; cfg_lsb = l[0];
        ctl = C_EN | C_MS | (m[0] ? C_CPOL : 0) | (m[1] ? C_CPHA : 0) | (l ? C_LSB : 0);
        wr(A_CTRL, ctl | C_HOLD);
        for (int k = 0; k < 2; k++) begin
          tx[k] = W'((m * 37 + l * 91 + k * 53 + 5) % 256);
          sw[k] = tx[k] ^ W'(8'hC3 + k * 17);
          wr(A_TXD, 32'(tx[k]));
        end
        idle(3); clear_mon;
        wr(A_CTRL, ctl);
        idle(120);
        for (int k = 0; k < 2; k++) begin
          chk($sformatf("R5 mode%0d lsb%0d slave rx word%0d", m, l, k), rcv[k], tx[k]);
          rd(A_RXD, v);
          chk($sformatf("R6 mode%0d lsb%0d master rx word%0d", m, l, k), v, sw[k]);
        end
        chk($sformatf("R6 mode%0d edge count", m), tog_cnt, 4 * W);
        chk($sformatf("R6 mode%0d idle level", m), sck, m % 2);
        chk($sformatf("R11 mode%0d even gaps", m), gap_ok, 2 * (2 * W - 1));
        chk($sformatf("R11 mode%0d short gaps", m), gap_bad, 0);
        chk($sformatf("R8 mode%0d one select burst", m), ss_rise, 1);
      end
    end

    // R7 / R2 / R10 loopback, full and empty queues
    cfg_cpol = 0; cfg_cpha = 0; cfg_lsb = 0;
    for (int i = 0; i < 8; i++) sw[i] = 8'hFF;
    wr(A_CTRL, C_EN | C_MS | C_LOOP | C_HOLD);
    for (int k = 0; k < 5; k++) wr(A_TXD, 17 * k + 3);
    rd(A_STAT, v); chk("R2 tx full status", v, 32'h09);
    wr(A_CTRL, C_EN | C_MS | C_LOOP);
    idle(220);
    rd(A_STAT, v); chk("R2 R10 rx full tx empty", v, 32'h06);
    for (int k = 0; k < 4; k++) begin
      rd(A_RXD, v); chk($sformatf("R7 loopback word%0d", k), v, 17 * k + 3);
    end
    rd(A_STAT, v); chk("R10 drained status", v, 32'h05);
    rd(A_RXD, v);
    rd(A_STAT, v); chk("R10 empty pop ignored", v, 32'h05);
    wr(A_TXD, 32'h5A); idle(60);
    rd(A_RXD, v); chk("R10 queue intact after empty pop", v, 32'h5A);

    // R9 queue resets
    wr(A_CTRL, C_EN | C_MS | C_HOLD);
    wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
    rd(A_STAT, v); chk("R9 tx loaded", v, 32'h01);
    wr(A_CTRL, C_EN | C_MS | C_HOLD | C_TCLR);
    rd(A_STAT, v); chk("R9 tx cleared", v, 32'h05);
    rd(A_CTRL, v); chk("R9 clear bit reads 0", v, 32'h106);
    idle(2); clear_mon;
    wr(A_CTRL, C_EN | C_MS); idle(60);
    chk("R9 nothing sent after clear", tog_cnt, 0);
    wr(A_CTRL, C_EN | C_MS | C_LOOP);
    wr(A_TXD, 32'h77); idle(60);
    rd(A_STAT, v); chk("R9 rx holds word", v, 32'h04);
    wr(A_CTRL, C_EN | C_MS | C_LOOP | C_RCLR);
    rd(A_STAT, v); chk("R9 rx cleared", v, 32'h05);

    // R8 manual and automatic select
    wr(A_CTRL, C_HOLD | C_MAN); wr(A_SEL, 32'hB); idle(2);
    chk("R8 manual select follows", ss_n, 4'hB);
    wr(A_SEL, 32'hF); idle(2);
    chk("R8 manual deselect all", ss_n, 4'hF);
    wr(A_CTRL, C_HOLD); wr(A_SEL, 32'hD); idle(2);
    chk("R8 auto select idle high", ss_n, 4'hF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule